// File: doc/BRIEF.md
# Two-Port Monitor Handshake Sequencer

This block is the host-side engine that drives a hardware-monitor microcontroller through two byte-wide ports: a data port and a command port. Each port access goes out as one bus transaction. A select bit picks the port and a write-enable bit picks the direction. The engine runs one of two operations, chosen when it accepts a start request.

The handshake operation brings the microcontroller into a known state. It does this by waiting for fixed status bytes on the two ports. The sensor read operation takes a 16-bit code, splits it into a bank and an index, and steps through the port exchange that returns one raw sensor byte.

Each wait step polls its port until the expected byte appears. A poll gives up after a parameterised number of attempts, and the attempt count restarts for every poll. When the operation ends, the engine pulses a done flag, reports whether a poll timed out, and presents a result byte. Both the flag and the byte stay valid until the next start.

Top module: `mon_port_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o and bus_req_o are 0 and result_o is 0x00.
- R2: With op_i=0 (handshake), the engine runs four steps in this order: it polls the data port for 0x08, writes 0x00 to the data port, polls the data port for 0x09, then polls the command port for 0xAC. A successful handshake leaves result_o=0xAC.
- R3: With op_i=1 (sensor read), code_i[15:8] is the bank and code_i[7:0] is the index. The engine writes the bank to the data port, polls the data port for 0x08, writes the index to the command port, polls the data port for 0x01, then reads the command port once. That last byte becomes result_o.
- R4: A poll makes at most POLL_LIMIT reads. A match on read number POLL_LIMIT still succeeds. If POLL_LIMIT reads all mismatch, the operation ends with err_o=1 and result_o=0x00.
- R5: The attempt count restarts at zero for every poll step. Each poll of one operation may therefore use up to POLL_LIMIT reads.
- R6: done_o is a one-cycle pulse, registered at the edge that completes the final (or failing) transaction. busy_o falls at that same edge. When every ack arrives in the cycle of its request, done_o rises exactly N edges after the edge that accepts start, where N is the number of transactions.
- R7: err_o and result_o hold their values from the done pulse until the next accepted start, which clears both to 0.
- R8: A start_i that arrives while busy_o=1 is ignored. The running operation finishes normally with a single done pulse, and no second operation follows.
- R9: bus_sel_o=0 selects the data port and 1 the command port. bus_we_o=1 marks a write. While bus_req_o=1 and bus_ack_i=0, the request, select, direction and write byte stay unchanged.
- R10: bus_req_o is asserted only while busy_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when idle |
| op_i | input | 1 | Operation: 0 handshake, 1 sensor read |
| code_i | input | 16 | Sensor code: bank in high byte, index in low byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last operation ended on a poll timeout |
| result_o | output | 8 | Result byte of the last operation |
| bus_req_o | output | 1 | Port transaction request |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_sel_o | output | 1 | 0 data port, 1 command port |
| bus_wdata_o | output | 8 | Write byte |
| bus_ack_i | input | 1 | Transaction completes this cycle |
| bus_rdata_i | input | 8 | Read byte, valid with bus_ack_i |

## Verification
With zero-wait acks, a sensor read whose polls each see L busy bytes takes 5+2L transactions. A handshake with the same lag takes 4+2L. A timeout ends after POLL_LIMIT+1 transactions in a read and POLL_LIMIT in a handshake. The bench drives start on a falling edge and counts falling edges until done_o is seen. It compares that count with the transaction total, so the pulse has to land on the exact edge. Result and error values are sampled on that same falling edge, and again some cycles later to confirm they hold.

// File: rtl/mon_seq_pkg.sv
package mon_seq_pkg;
  typedef enum logic [1:0] {
    STEP_WR   = 2'd0,
    STEP_POLL = 2'd1,
    STEP_RD   = 2'd2
  } step_kind_e;

  typedef struct packed {
    step_kind_e  kind;
    logic        sel;   // 0 data port, 1 command port
    logic [7:0]  val;   // write byte or expected poll byte
    logic        last;
  } step_t;

  localparam logic PORT_DATA = 1'b0;
  localparam logic PORT_CMD  = 1'b1;

  localparam logic [7:0] MAGIC_READY  = 8'h08;
  localparam logic [7:0] MAGIC_CLEAR  = 8'h00;
  localparam logic [7:0] MAGIC_ACK1   = 8'h09;
  localparam logic [7:0] MAGIC_SYNC   = 8'hAC;
  localparam logic [7:0] MAGIC_VALUE  = 8'h01;

  localparam int STEP_W = 3;
endpackage

// File: rtl/mon_step_rom.sv
module mon_step_rom
  import mon_seq_pkg::*;
(
  input  logic              op_i,
  input  logic [STEP_W-1:0] idx_i,
  input  logic [15:0]       code_i,
  output step_t             step_o
);
  always_comb begin
    step_o = '{kind: STEP_RD, sel: PORT_CMD, val: 8'h00, last: 1'b1};
    if (!op_i) begin
      unique case (idx_i)
        3'd0: step_o = '{kind: STEP_POLL, sel: PORT_DATA, val: MAGIC_READY, last: 1'b0};
        3'd1: step_o = '{kind: STEP_WR,   sel: PORT_DATA, val: MAGIC_CLEAR, last: 1'b0};
        3'd2: step_o = '{kind: STEP_POLL, sel: PORT_DATA, val: MAGIC_ACK1,  last: 1'b0};
        default: step_o = '{kind: STEP_POLL, sel: PORT_CMD, val: MAGIC_SYNC, last: 1'b1};
      endcase
    end else begin
      unique case (idx_i)
        3'd0: step_o = '{kind: STEP_WR,   sel: PORT_DATA, val: code_i[15:8], last: 1'b0};
        3'd1: step_o = '{kind: STEP_POLL, sel: PORT_DATA, val: MAGIC_READY,  last: 1'b0};
        3'd2: step_o = '{kind: STEP_WR,   sel: PORT_CMD,  val: code_i[7:0],  last: 1'b0};
        3'd3: step_o = '{kind: STEP_POLL, sel: PORT_DATA, val: MAGIC_VALUE,  last: 1'b0};
        default: step_o = '{kind: STEP_RD, sel: PORT_CMD, val: 8'h00, last: 1'b1};
      endcase
    end
  end
endmodule

// File: rtl/mon_poll_timer.sv
module mon_poll_timer #(
  parameter int POLL_LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = $clog2(POLL_LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  // the current read is the final allowed attempt
  assign last_o = (cnt_q == CW'(POLL_LIMIT - 1));
endmodule

// File: rtl/mon_port_seq.sv
module mon_port_seq
  import mon_seq_pkg::*;
#(
  parameter int POLL_LIMIT = 1000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        op_i,
  input  logic [15:0] code_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic [7:0]  result_o,
  output logic        bus_req_o,
  output logic        bus_we_o,
  output logic        bus_sel_o,
  output logic [7:0]  bus_wdata_o,
  input  logic        bus_ack_i,
  input  logic [7:0]  bus_rdata_i
);
  logic              busy_q, done_q, err_q, op_q;
  logic [15:0]       code_q;
  logic [STEP_W-1:0] step_q;
  logic [7:0]        res_q;
  step_t             cur;
  logic              xfer, hit, adv, fail, tmr_last, accept;

  mon_step_rom u_rom (
    .op_i   (op_q),
    .idx_i  (step_q),
    .code_i (code_q),
    .step_o (cur)
  );

  assign accept = start_i && !busy_q;
  assign xfer   = busy_q && bus_ack_i;
  assign hit    = (cur.kind != STEP_POLL) || (bus_rdata_i == cur.val);
  assign adv    = xfer && hit;
  assign fail   = xfer && !hit && tmr_last;

  mon_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (adv || accept),
    .inc_i  (xfer && !hit && !tmr_last),
    .last_o (tmr_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      op_q   <= 1'b0;
      code_q <= '0;
      step_q <= '0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        op_q   <= op_i;
        code_q <= code_i;
        step_q <= '0;
        err_q  <= 1'b0;
        res_q  <= '0;
      end else if (adv) begin
        step_q <= step_q + 1'b1;
        // command-port reads that complete a step carry the result
        if (cur.kind != STEP_WR && cur.sel == PORT_CMD) res_q <= bus_rdata_i;
        if (cur.last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (fail) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        err_q  <= 1'b1;
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign result_o    = res_q;
  assign bus_req_o   = busy_q;
  assign bus_we_o    = (cur.kind == STEP_WR);
  assign bus_sel_o   = cur.sel;
  assign bus_wdata_o = (cur.kind == STEP_WR) ? cur.val : 8'h00;
endmodule

// File: rtl/mon_port_seq_chk.sv
module mon_port_seq_chk #(
  parameter int POLL_LIMIT = 1000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic [7:0] result_o,
  input logic       bus_req_o,
  input logic       bus_we_o,
  input logic       bus_sel_o,
  input logic [7:0] bus_wdata_o,
  input logic       bus_ack_i
);
  localparam int RW = $clog2(POLL_LIMIT + 2);
  logic [RW-1:0] run_q;
  logic          sel_q;

  // consecutive reads of one port, restarted by a write or by idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      sel_q <= 1'b0;
    end else if (!busy_o) begin
      run_q <= '0;
    end else if (bus_req_o && bus_ack_i) begin
      sel_q <= bus_sel_o;
      if (bus_we_o)                              run_q <= '0;
      else if (run_q != '0 && bus_sel_o == sel_q) run_q <= run_q + 1'b1;
      else                                       run_q <= RW'(1);
    end
  end

  assert_poll_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RW'(POLL_LIMIT));

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_err_on_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);

  assert_hold_status_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !$rose(busy_o)) |-> ($stable(err_o) && $stable(result_o)));

  assert_req_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_sel_o) &&
                                   $stable(bus_we_o) && $stable(bus_wdata_o)));

  assert_req_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> busy_o);
endmodule

bind mon_port_seq mon_port_seq_chk #(.POLL_LIMIT(POLL_LIMIT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .result_o    (result_o),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_sel_o   (bus_sel_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_ack_i   (bus_ack_i)
);

// File: tb/mon_port_seq_bench.sv
module mon_port_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op = 1'b0;
  logic [15:0] code = '0;
  logic busy, done, err, req, we, sel, ack;
  logic [7:0] result, wdata, rdata;

  // microcontroller model state
  logic [7:0] d_cur, c_cur, bank_m, lag_cnt, lag_cfg;
  logic prep_stb = 1'b0;
  logic [7:0] prep_lag = '0, prep_init = '0;
  logic slow = 1'b0, ack_en = 1'b1;

  int n_tests = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mon_port_seq #(.POLL_LIMIT(LIMIT)) u_mon_port_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .code_i(code),
    .busy_o(busy), .done_o(done), .err_o(err), .result_o(result),
    .bus_req_o(req), .bus_we_o(we), .bus_sel_o(sel), .bus_wdata_o(wdata),
    .bus_ack_i(ack), .bus_rdata_i(rdata)
  );

  function automatic logic [7:0] sens(input logic [7:0] b, input logic [7:0] i);
    return (b * 8'd29) ^ i ^ 8'h3C;
  endfunction

  assign ack   = req && ack_en;
  assign rdata = (lag_cnt != 0) ? 8'hEE : (sel ? c_cur : d_cur);

  always @(negedge clk) ack_en <= slow ? ~ack_en : 1'b1;

  always @(posedge clk) begin
    if (prep_stb) begin
      d_cur   <= 8'h08;
      c_cur   <= 8'h00;
      lag_cnt <= prep_init;
      lag_cfg <= prep_lag;
    end else if (req && ack) begin
      if (we && !sel) begin
        lag_cnt <= lag_cfg;
        if (wdata == 8'h00) begin d_cur <= 8'h09; c_cur <= 8'hAC; end
        else begin d_cur <= 8'h08; bank_m <= wdata; end
      end else if (we && sel) begin
        lag_cnt <= lag_cfg;
        d_cur   <= 8'h01;
        c_cur   <= sens(bank_m, wdata);
      end else if (lag_cnt != 0) begin
        lag_cnt <= lag_cnt - 1'b1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic o, input logic [15:0] c, input logic [7:0] lag,
                        output int n, output logic e, output logic [7:0] r);
    @(negedge clk);
    prep_stb = 1'b1; prep_lag = lag; prep_init = o ? 8'd0 : lag;
    @(negedge clk);
    prep_stb = 1'b0;
    start = 1'b1; op = o; code = c;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
    end
    e = err; r = result;
  endtask

  typedef struct packed {
    logic        op;
    logic [15:0] code;
    logic [7:0]  lag;
    logic        err;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 16'h0107, 8'd0, 1'b0},
    '{1'b1, 16'h0218, 8'd3, 1'b0},
    '{1'b1, 16'h0500, 8'd7, 1'b0},
    '{1'b1, 16'h0342, 8'd8, 1'b1},
    '{1'b0, 16'h0000, 8'd0, 1'b0},
    '{1'b0, 16'h0000, 8'd7, 1'b0},
    '{1'b0, 16'h0000, 8'd8, 1'b1},
    '{1'b1, 16'hFFFF, 8'd1, 1'b0}
  };

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin : main
    int n, dn, exp_n;
    logic e;
    logic [7:0] r, exp_r;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 err", err, 0);
    chk("R1 req", req, 0);   chk("R1 result", result, 0);
    rst_n = 1'b1;

    for (int k = 0; k < 8; k++) begin
      run_op(VECS[k].op, VECS[k].code, VECS[k].lag, n, e, r);
      if (VECS[k].op) begin
        exp_n = VECS[k].err ? 1 + LIMIT : 5 + 2 * int'(VECS[k].lag);
        exp_r = VECS[k].err ? 8'h00 : sens(VECS[k].code[15:8], VECS[k].code[7:0]);
        chk("R3 read result", r, exp_r);
      end else begin
        exp_n = VECS[k].err ? LIMIT : 4 + 2 * int'(VECS[k].lag);
        exp_r = VECS[k].err ? 8'h00 : 8'hAC;
        chk("R2 handshake result", r, exp_r);
      end
      chk("R4 err flag", e, VECS[k].err);
      chk("R6 done latency", n, exp_n);
      @(negedge clk);
      chk("R6 done one cycle", done, 0);
      chk("R6 busy low", busy, 0);
    end

    // R5: two polls of one read each use LIMIT-1 mismatches; total exceeds LIMIT
    run_op(1'b1, 16'h0A0B, 8'(LIMIT - 1), n, e, r);
    chk("R5 per-poll restart err", e, 0);
    chk("R5 per-poll restart result", r, sens(8'h0A, 8'h0B));

    // R7 hold after done, then clear at next start
    repeat (10) @(negedge clk);
    chk("R7 result held", result, sens(8'h0A, 8'h0B));
    run_op(1'b1, 16'h0C0D, 8'd8, n, e, r);
    repeat (6) @(negedge clk);
    chk("R7 err held", err, 1);
    start = 1'b1; op = 1'b1; code = 16'h0102;
    @(negedge clk);
    start = 1'b0;
    chk("R7 err cleared at start", err, 0);
    chk("R7 result cleared at start", result, 0);
    while (!done) @(negedge clk);

    // R8 start while busy ignored
    @(negedge clk);
    prep_stb = 1'b1; prep_lag = 8'd2; prep_init = 8'd0;
    @(negedge clk);
    prep_stb = 1'b0; start = 1'b1; op = 1'b1; code = 16'h0123;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; op = 1'b0; code = 16'h0000;
    @(negedge clk);
    start = 1'b0;
    dn = 0;
    for (int t = 0; t < 40; t++) begin
      if (done) dn++;
      @(negedge clk);
    end
    chk("R8 single done", dn, 1);
    chk("R8 result of first op", result, sens(8'h01, 8'h23));
    chk("R8 idle after", busy, 0);

    // R9 acks every other cycle
    slow = 1'b1;
    run_op(1'b1, 16'h0456, 8'd2, n, e, r);
    slow = 1'b0;
    chk("R9 slow ack result", r, sens(8'h04, 8'h56));
    chk("R9 slow ack err", e, 0);
    chk("R10 no req when idle", req, busy);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule